// File: doc/BRIEF.md
# Overflow-Conditional Relative Branch Unit

This unit executes one conditional branch of a processor pipeline. The branch fires when the arithmetic overflow flag is set. Each cycle it receives a 16-bit instruction word, the program counter of that word and the overflow flag. It returns the program counter for the next fetch, a taken strobe and a flush request. The branch is recognised when the upper byte of the instruction equals the opcode 0xE4. The lower byte is a signed displacement counted in 16-bit words.

The program counter addresses bytes and is always even. By the time the branch executes, the counter has already moved past the one-word branch. For that reason the displacement is doubled and added to the incremented address. A branch that is not taken finishes in a single cycle. A taken branch writes the new address in its own cycle and then spends one idle cycle, which is signalled on `flush`. During that cycle the word already prefetched is discarded and the inputs are ignored. The branch changes no status flags.

Top module: `ovf_branch_unit`

## Requirements
- R1: While `rst_n` is low, `flush` is 0. The first cycle after reset is not a flush cycle.
- R2: An instruction is a branch when `instr_valid` is 1, `instr[15:8]` equals 0xE4 and the cycle is not a flush cycle. If a branch arrives with `ovf` = 1, then `taken` is 1 in the same cycle. In that case `pc_next` = (`pc_in` with bit 0 cleared) + 2 + 2·n, where n = `instr[7:0]` read as two's complement (−128..127).
- R3: A branch with `ovf` = 0 gives `taken` = 0 and `pc_next` = (`pc_in` with bit 0 cleared) + 2. The following cycle is not a flush cycle.
- R4: `flush` is 1 in exactly the one cycle that follows a cycle with `taken` = 1, and 0 in every other cycle.
- R5: In a flush cycle the unit ignores `instr_valid`, `instr` and `ovf`. It drives `taken` = 0 and holds `pc_next` = `pc_in` with bit 0 cleared, so the idle cycle does not advance the counter.
- R6: A valid word whose upper byte is not 0xE4 gives `taken` = 0 and `pc_next` = `pc_in` + 2 (bit 0 cleared). With `instr_valid` = 0, `pc_next` equals `pc_in` with bit 0 cleared.
- R7: Bit 0 of `pc_in` never affects the result, and `pc_next[0]` is always 0.
- R8: All address arithmetic wraps modulo 2^21. A branch near either end of the address space crosses the boundary without any error indication.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr_valid | input | 1 | `instr` holds a word to execute this cycle |
| instr | input | 16 | Instruction word: opcode in [15:8], displacement in [7:0] |
| pc_in | input | 21 | Byte address of the word after fetch, before increment |
| ovf | input | 1 | Arithmetic overflow flag |
| pc_next | output | 21 | Address for the next fetch |
| taken | output | 1 | Branch taken this cycle |
| flush | output | 1 | Idle cycle: prefetched word is discarded |

## Verification
The only internal state is the register that marks the second cycle of a taken branch. If that register is wrong, the error shows at the ports in the very next cycle, in one of three ways. A taken branch may not raise `flush`. A flush cycle may advance `pc_next` or let a second branch fire. Or a spurious `flush` may freeze the counter for a cycle. The bench sweeps every displacement with both flag values at several addresses, including both ends of the address space. After each taken branch it offers a competing branch in the idle cycle and checks that the cycle stays quiet.

// File: rtl/ovf_branch_unit.sv
module ovf_branch_unit #(
  parameter int PC_W   = 21,
  parameter int DISP_W = 8,
  parameter int INS_W  = 16,
  parameter logic [INS_W-DISP_W-1:0] OPCODE = 8'hE4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             instr_valid,
  input  logic [INS_W-1:0] instr,
  input  logic [PC_W-1:0]  pc_in,
  input  logic             ovf,
  output logic [PC_W-1:0]  pc_next,
  output logic             taken,
  output logic             flush
);
  localparam int EXT_W = PC_W - DISP_W;

  logic            idle_q;
  logic            is_branch;
  logic [PC_W-1:0] base, seq, offset, target;

  assign is_branch = instr_valid && !idle_q && (instr[INS_W-1:DISP_W] == OPCODE);
  assign taken     = is_branch && ovf;

  assign base   = {pc_in[PC_W-1:1], 1'b0};
  assign seq    = base + PC_W'(2);
  assign offset = {{(EXT_W-1){instr[DISP_W-1]}}, instr[DISP_W-1:0], 1'b0};
  assign target = seq + offset;

  always_comb begin
    if (idle_q || !instr_valid) pc_next = base;
    else if (taken)             pc_next = target;
    else                        pc_next = seq;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) idle_q <= 1'b0;
    else        idle_q <= taken;
  end

  assign flush = idle_q;
endmodule

// File: rtl/ovf_branch_unit_chk.sv
module ovf_branch_unit_chk #(
  parameter int PC_W = 21
) (
  input logic            clk,
  input logic            rst_n,
  input logic            instr_valid,
  input logic            ovf,
  input logic [PC_W-1:0] pc_in,
  input logic [PC_W-1:0] pc_next,
  input logic            taken,
  input logic            flush
);
  // R4
  flush_follows_taken_chk: assert property (@(posedge clk) disable iff (!rst_n)
    taken |=> flush);

  // R4
  flush_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !flush);

  // R5
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!taken && pc_next == {pc_in[PC_W-1:1], 1'b0}));

  // R3
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |-> !taken);

  // R7
  pc_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_next[0] == 1'b0);

  // R6
  invalid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |-> (!taken && pc_next == {pc_in[PC_W-1:1], 1'b0}));
endmodule

bind ovf_branch_unit ovf_branch_unit_chk #(.PC_W(PC_W)) chk (
  .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .ovf(ovf),
  .pc_in(pc_in), .pc_next(pc_next), .taken(taken), .flush(flush)
);

// File: tb/ovf_branch_unit_test.sv
`timescale 1ns/1ps
module ovf_branch_unit_test;
  localparam int PC_W = 21;
  localparam int MASK = (1 << PC_W) - 1;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            instr_valid = 1'b0;
  logic [15:0]     instr = '0;
  logic [PC_W-1:0] pc_in = '0;
  logic            ovf = 1'b0;
  logic [PC_W-1:0] pc_next;
  logic            taken;
  logic            flush;

  int checks = 0;
  int errors = 0;
  bit exp_flush = 1'b0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  ovf_branch_unit uut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .pc_in(pc_in), .ovf(ovf), .pc_next(pc_next), .taken(taken), .flush(flush)
  );

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic apply(bit v, logic [15:0] ins, int pc, bit o);
    int base, e_pc, sn;
    bit e_tk;
    @(negedge clk);
    instr_valid = v; instr = ins; pc_in = PC_W'(pc); ovf = o;
    #2;
    base = pc & MASK & ~1;
    sn = int'($signed(ins[7:0]));
    e_tk = 1'b0;
    if (exp_flush || !v) e_pc = base;
    else if (ins[15:8] == 8'hE4 && o) begin
      e_tk = 1'b1;
      e_pc = (base + 2 + 2 * sn) & MASK;
    end else e_pc = (base + 2) & MASK;
    check("R4 flush", int'(flush), int'(exp_flush));
    if (exp_flush) check("R5 idle taken", int'(taken), 0);
    else if (ins[15:8] == 8'hE4 && v) check(o ? "R2 taken" : "R3 taken", int'(taken), int'(e_tk));
    else check("R6 taken", int'(taken), 0);
    check(exp_flush ? "R5 pc" : (e_tk ? "R2/R8 pc" : "R3/R6 pc"), int'(pc_next), e_pc);
    check("R7 bit0", int'(pc_next[0]), 0);
    exp_flush = e_tk;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int pcs[6];
    pcs[0] = 'h000100; pcs[1] = 'h000001; pcs[2] = 'h0ABCDE;
    pcs[3] = 'h1FFFFE; pcs[4] = 'h000000; pcs[5] = 'h1FFF81;
    repeat (2) @(negedge clk);
    instr_valid = 1'b1; instr = 16'hE405; ovf = 1'b1;
    #2 check("R1 reset flush", int'(flush), 0);
    @(negedge clk);
    check("R1 reset flush", int'(flush), 0);
    instr_valid = 1'b0;
    rst_n = 1'b1;
    // R1: first cycle after reset is not a flush cycle
    apply(1'b0, 16'h0000, 'h40, 1'b0);

    // R2 R3 R8: every displacement, both flag values, several addresses
    for (int p = 0; p < 6; p++)
      for (int n = 0; n < 256; n++)
        for (int o = 0; o < 2; o++) begin
          apply(1'b1, {8'hE4, 8'(n)}, pcs[p], bit'(o));
          // R5: competing branch in the idle cycle must be ignored
          if (exp_flush) apply(1'b1, 16'hE47F, pcs[p] + 6, 1'b1);
        end

    // R6: other opcodes and invalid words
    apply(1'b1, 16'hE504, 'h200, 1'b1);
    apply(1'b1, 16'h6404, 'h200, 1'b1);
    apply(1'b0, 16'hE404, 'h201, 1'b1);
    // R4: back-to-back taken branches
    apply(1'b1, 16'hE480, 'h000010, 1'b1);
    apply(1'b1, 16'hE401, 'h1FFF12, 1'b1);
    apply(1'b1, 16'hE401, 'h000300, 1'b1);
    apply(1'b1, 16'hE401, 'h000300, 1'b0);
    apply(1'b1, 16'h0000, 'h000400, 1'b0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule